// File: doc/BRIEF.md
# Carry-Less Multiplier with Operand-Half Select

This block multiplies two 64-bit polynomials over GF(2) and returns their 128-bit product. Each of its two 128-bit operands holds two 64-bit halves. An 8-bit select byte chooses one half of each operand to feed the multiplier. Partial products are combined with XOR, so no carry ever moves from one bit position to the next. This makes the unit a polynomial multiplier, not an integer multiplier. It is intended as the arithmetic core of a CRC folding datapath, where a data chunk is multiplied by precomputed residue constants.

Operands enter through a valid/ready handshake. In the default registered build the product sits in an output register that holds its value under backpressure. A parameter can instead select a purely combinational build, in which the handshake signals pass straight through.

Top module: `clmul_unit`

## Requirements
- R1: `result` is the GF(2) product of the two selected halves: bit k is the XOR over all i+j=k of `a_half[i] & b_half[j]`, with no carries.
- R2: A select byte whose bit 0 and bit 4 are both 0 multiplies the low half of `op_b` (bits 63..0) by the low half of `op_a` (bits 63..0).
- R3: A select byte with bit 0 = 1 and bit 4 = 0 multiplies the low half of `op_b` by the high half of `op_a` (bits 127..64).
- R4: A select byte with bit 0 = 0 and bit 4 = 1 multiplies the high half of `op_b` (bits 127..64) by the low half of `op_a`.
- R5: A select byte with bit 0 = 1 and bit 4 = 1 multiplies the high half of `op_b` by the high half of `op_a`.
- R6: Bit 127 of `result` is always 0 while `out_valid` is high. The product of the two all-ones halves has bit 126 set.
- R7: Select bits 1, 2, 3, 5, 6 and 7 have no effect on `result`.
- R8: In the registered build, `out_valid` rises in the cycle after an input is accepted (`in_valid && in_ready` at a clock edge). It falls after the output is taken (`out_valid && out_ready`) if no new input is accepted at that same edge.
- R9: While `out_valid` is high and `out_ready` is low, `result` and `out_valid` hold their values and `in_ready` is low, so no new input is accepted.
- R10: After reset, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operands and select are presented |
| in_ready | output | 1 | The block can accept an input this cycle |
| op_a | input | 128 | First operand, two 64-bit halves |
| op_b | input | 128 | Second operand, two 64-bit halves |
| sel | input | 8 | Half select byte; bit 0 picks the `op_a` half, bit 4 picks the `op_b` half |
| out_valid | output | 1 | `result` holds a product |
| out_ready | input | 1 | The consumer takes `result` this cycle |
| result | output | 128 | Carry-less product of the selected halves |

## Verification
The handshake assertions assume that the consumer drives `out_ready` to a known level every cycle. They also assume that an input counts as accepted only at a clock edge where `in_valid` and `in_ready` are both high. The bench changes inputs only on falling edges, so every value it drives is stable across the rising edge that samples it. It keeps `in_valid` asserted through stalls, which exercises the rule that a blocked input is not consumed. The product checks use a serial shift-and-XOR reference. Random operands are paired with every select code, and the unused select bits are filled with random values.

// File: rtl/clmul_pkg.sv
package clmul_pkg;

  localparam int SEL_W     = 8;
  localparam int A_SEL_BIT = 0;
  localparam int B_SEL_BIT = 4;

  typedef enum logic {
    HALF_LO = 1'b0,
    HALF_HI = 1'b1
  } half_sel_e;

  typedef struct packed {
    half_sel_e pick_a;
    half_sel_e pick_b;
  } half_pair_t;

  // Only the two steering bits carry meaning; the others are dropped here.
  function automatic half_pair_t decode_sel(input logic [SEL_W-1:0] code);
    half_pair_t d;
    d.pick_a = half_sel_e'(code[A_SEL_BIT]);
    d.pick_b = half_sel_e'(code[B_SEL_BIT]);
    return d;
  endfunction

endpackage

// File: rtl/clmul_half_pick.sv
module clmul_half_pick
  import clmul_pkg::*;
#(
  parameter int HALF_W = 64
) (
  input  logic [2*HALF_W-1:0] operand,
  input  half_sel_e           pick,
  output logic [HALF_W-1:0]   half_out
);

  always_comb begin
    if (pick == HALF_HI) half_out = operand[2*HALF_W-1:HALF_W];
    else                 half_out = operand[HALF_W-1:0];
  end

endmodule

// File: rtl/clmul_gf2_core.sv
module clmul_gf2_core #(
  parameter int HALF_W = 64
) (
  input  logic [HALF_W-1:0]   mul_a,
  input  logic [HALF_W-1:0]   mul_b,
  output logic [2*HALF_W-1:0] prod
);

  localparam int PROD_W = 2 * HALF_W;

  // Parity of one anti-diagonal of the partial-product array.
  function automatic logic column_parity(input logic [HALF_W-1:0] a,
                                         input logic [HALF_W-1:0] b,
                                         input int k);
    logic p;
    p = 1'b0;
    for (int i = 0; i < HALF_W; i++) begin
      if ((k - i) >= 0 && (k - i) < HALF_W) p = p ^ (a[i] & b[k-i]);
    end
    return p;
  endfunction

  for (genvar k = 0; k < PROD_W - 1; k++) begin : g_col
    assign prod[k] = column_parity(mul_a, mul_b, k);
  end
  assign prod[PROD_W-1] = 1'b0;

  // R1: a zero factor must give a zero product
  always_comb begin
    if (mul_a == '0 || mul_b == '0) begin
      assert_zero_factor_R1: assert (prod == '0);
    end
  end

endmodule

// File: rtl/clmul_unit.sv
module clmul_unit
  import clmul_pkg::*;
#(
  parameter int HALF_W     = 64,
  parameter bit REGISTERED = 1'b1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [2*HALF_W-1:0]  op_a,
  input  logic [2*HALF_W-1:0]  op_b,
  input  logic [SEL_W-1:0]     sel,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [2*HALF_W-1:0]  result
);

  localparam int PROD_W = 2 * HALF_W;

  half_pair_t          picks;
  logic [HALF_W-1:0]   a_half;
  logic [HALF_W-1:0]   b_half;
  logic [PROD_W-1:0]   prod_comb;
  logic                accept;
  logic                drain;

  assign picks = decode_sel(sel);

  clmul_half_pick #(.HALF_W(HALF_W)) u_pick_a (
    .operand (op_a),
    .pick    (picks.pick_a),
    .half_out(a_half)
  );

  clmul_half_pick #(.HALF_W(HALF_W)) u_pick_b (
    .operand (op_b),
    .pick    (picks.pick_b),
    .half_out(b_half)
  );

  clmul_gf2_core #(.HALF_W(HALF_W)) u_core (
    .mul_a(a_half),
    .mul_b(b_half),
    .prod (prod_comb)
  );

  assign accept = in_valid && in_ready;
  assign drain  = out_valid && out_ready;

  if (REGISTERED) begin : g_reg
    logic              vld_q;
    logic [PROD_W-1:0] res_q;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        vld_q <= 1'b0;
        res_q <= '0;
      end else begin
        if (accept)     vld_q <= 1'b1;
        else if (drain) vld_q <= 1'b0;
        if (accept)     res_q <= prod_comb;
      end
    end

    assign in_ready  = !vld_q || out_ready;
    assign out_valid = vld_q;
    assign result    = res_q;

    assert_accept_to_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> out_valid);

    assert_drain_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (drain && !accept) |=> !out_valid);

    assert_stall_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(result)));

    assert_top_bit_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> !result[PROD_W-1]);
  end else begin : g_comb
    assign in_ready  = out_ready;
    assign out_valid = in_valid;
    assign result    = prod_comb;
  end

endmodule

// File: tb/clmul_unit_bench.sv
module clmul_unit_bench;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         in_valid;
  logic         in_ready;
  logic [127:0] op_a;
  logic [127:0] op_b;
  logic [7:0]   sel;
  logic         out_valid;
  logic         out_ready;
  logic [127:0] result;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  clmul_unit u_clmul_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .op_a(op_a), .op_b(op_b), .sel(sel), .out_valid(out_valid),
    .out_ready(out_ready), .result(result)
  );

  // Serial shift-and-XOR reference.
  function automatic logic [127:0] ref_mul(input logic [63:0] x, input logic [63:0] y);
    logic [127:0] acc;
    logic [127:0] sh;
    acc = '0;
    sh  = {64'd0, x};
    for (int i = 0; i < 64; i++) begin
      if (y[i]) acc = acc ^ sh;
      sh = sh << 1;
    end
    return acc;
  endfunction

  function automatic logic [127:0] expect_of(input logic [127:0] a, input logic [127:0] b,
                                             input logic [7:0] s);
    logic [63:0] ah;
    logic [63:0] bh;
    ah = s[0] ? a[127:64] : a[63:0];
    bh = s[4] ? b[127:64] : b[63:0];
    return ref_mul(ah, bh);
  endfunction

  task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // One operation with the consumer ready; result checked a cycle after accept.
  task automatic run_op(input string tag, input logic [127:0] a, input logic [127:0] b,
                        input logic [7:0] s);
    @(negedge clk);
    op_a = a; op_b = b; sel = s; in_valid = 1'b1; out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check({tag, " out_valid R8"}, {127'd0, out_valid}, 128'd1);
    check(tag, result, expect_of(a, b, s));
  endtask

  initial begin
    #400000;
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [127:0] a1, b1, a2, b2, e1;
    logic [7:0]   s1;
    void'($urandom(32'd1234));
    rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b0;
    op_a = '0; op_b = '0; sel = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("reset out_valid R10", {127'd0, out_valid}, 128'd0);
    check("reset in_ready R10",  {127'd0, in_ready},  128'd1);

    a1 = {64'hFEDC_BA98_7654_3210, 64'h0123_4567_89AB_CDEF};
    b1 = {64'h8000_0000_0000_0001, 64'h0000_0000_0000_0003};
    run_op("sel 0x00 R2", a1, b1, 8'h00);
    run_op("sel 0x01 R3", a1, b1, 8'h01);
    run_op("sel 0x10 R4", a1, b1, 8'h10);
    run_op("sel 0x11 R5", a1, b1, 8'h11);
    run_op("zero factor R1", a1, '0, 8'h11);
    // carries would differ: 3*3 gives 9 in integer, 5 over GF(2)
    run_op("no carry R1", 128'd3, 128'd3, 8'h00);
    check("no carry value R1", result, 128'd5);
    run_op("all ones R6", '1, '1, 8'h11);
    check("top bits R6", {126'd0, result[127:126]}, 128'd1);
    run_op("single top bits R6", {1'b1, 127'd0}, {1'b1, 127'd0}, 8'h11);
    check("bit126 R6", result, {2'b01, 126'd0});
    // ignored select bits
    run_op("sel 0xEE R7", a1, b1, 8'hEE);
    check("sel 0xEE equals 0x00 R7", result, expect_of(a1, b1, 8'h00));
    run_op("sel 0xFF R7", a1, b1, 8'hFF);
    check("sel 0xFF equals 0x11 R7", result, expect_of(a1, b1, 8'h11));

    // random operands, every select code, random don't-care bits
    for (int n = 0; n < 200; n++) begin
      logic [7:0] s;
      a2 = {$urandom, $urandom, $urandom, $urandom};
      b2 = {$urandom, $urandom, $urandom, $urandom};
      s  = 8'($urandom) & 8'hEE;
      s[0] = n[0];
      s[4] = n[1];
      run_op("random R1", a2, b2, s);
      check("random msb R6", {127'd0, result[127]}, 128'd0);
    end

    // backpressure
    @(negedge clk);
    out_ready = 1'b0;
    a1 = {$urandom, $urandom, $urandom, $urandom};
    b1 = {$urandom, $urandom, $urandom, $urandom};
    s1 = 8'h10;
    e1 = expect_of(a1, b1, s1);
    op_a = a1; op_b = b1; sel = s1; in_valid = 1'b1;
    @(negedge clk);
    a2 = {$urandom, $urandom, $urandom, $urandom};
    b2 = {$urandom, $urandom, $urandom, $urandom};
    op_a = a2; op_b = b2; sel = 8'h01;
    check("stall valid R9", {127'd0, out_valid}, 128'd1);
    check("stall in_ready R9", {127'd0, in_ready}, 128'd0);
    check("stall result R9", result, e1);
    repeat (3) @(negedge clk);
    check("stall hold valid R9", {127'd0, out_valid}, 128'd1);
    check("stall hold result R9", result, e1);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("after stall next R8", result, expect_of(a2, b2, 8'h01));
    check("after stall valid R8", {127'd0, out_valid}, 128'd1);
    @(negedge clk);
    check("drained R8", {127'd0, out_valid}, 128'd0);

    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule